// File: doc/BRIEF.md
# Addressing-Form Byte Decoder

This block parses the memory-operand descriptor that follows the opcode of an x86-style instruction. Bytes arrive one per cycle over a valid/ready handshake. The first byte is the addressing-form byte. It may be followed by a scale-index-base byte and then by a displacement of 0, 1, 2 or 4 bytes. The block decides from the bytes already seen how many more it must take. When the last one has been taken, it presents the decoded fields and a one-cycle completion pulse.

A mode input selects 16-bit or 32-bit addressing. Three register-extension inputs widen the register numbers to four bits, and they have an effect only in 32-bit addressing. The mode and the extension inputs are captured together with the first byte and govern the whole descriptor. Opcode lookup, prefix handling and address arithmetic belong to neighbouring blocks.

The control is a four-state machine:
- `S_IDLE` waits for the first byte. It leaves for `S_SIB` when a scale-index-base byte is needed, for `S_DISP` when a displacement follows, and otherwise for `S_DONE`.
- `S_SIB` takes the scale-index-base byte. It leaves for `S_DISP` when the resulting length is non-zero, and otherwise for `S_DONE`.
- `S_DISP` takes displacement bytes and leaves for `S_DONE` after the last one.
- `S_DONE` lasts one cycle. It raises the completion pulse, drops ready, and always returns to `S_IDLE`.

Top module: `addr_form_decoder`

## Requirements
- R1: The first byte is split into mod (bits 7:6), reg (bits 5:3) and rm (bits 2:0). They are reported on `f_mod`, `f_reg[2:0]` and `f_rm[2:0]`.
- R2: With `wide_mode`=0 (16-bit addressing), the displacement length depends only on mod and rm:
  - mod=00 takes 2 bytes when rm=6 and no bytes for any other rm.
  - mod=01 takes 1 byte.
  - mod=10 takes 2 bytes.
  - No scale-index-base byte is ever taken in this mode.
- R3: With `wide_mode`=1 (32-bit addressing), when rm≠4:
  - mod=00 takes 4 bytes when rm=5 and no bytes otherwise.
  - mod=01 takes 1 byte.
  - mod=10 takes 4 bytes.
- R4: With `wide_mode`=1, mod≠11 and rm=4, one scale-index-base byte follows the first byte and `has_sib`=1. Its bits 7:6 go to `sib_scale`, bits 5:3 to `sib_index[2:0]` and bits 2:0 to `sib_base[2:0]`. In this case `f_rm` reports 4 and is not extended.
- R5: When a scale-index-base byte is present, the merged 4-bit base value (extension bit included) decides the mod=00 length. A base of 5 gives 4 bytes and any other base gives none. For mod=01 the length is 1 byte and for mod=10 it is 4 bytes, whatever the base.
- R6: Displacement bytes arrive least significant first and are reported on `disp_val`.
  - A 1-byte displacement is sign-extended to 32 bits in wide mode.
  - In narrow mode it is sign-extended to 16 bits and bits 31:16 are 0.
  - `disp_len` reports the byte count.
- R7: In wide mode the extension inputs supply bit 3 of the fields:
  - `ext_r` gives bit 3 of reg.
  - `ext_x` gives bit 3 of the index.
  - `ext_b` gives bit 3 of the base when a scale-index-base byte is present, and bit 3 of rm otherwise, including in register form.
  - In narrow mode every bit 3 is 0.
- R8: With mod=11, only the first byte is taken. `is_reg`=1, `reg_idx` equals the (extended) rm, `has_sib`=0 and `disp_len`=0.
- R9: `done` is high for exactly the one cycle after the last byte of a descriptor is accepted, and `in_ready` is low in that cycle. The decoded outputs then hold their values until the next first byte is accepted.
- R10: After reset every field, length and value output is 0, `is_reg`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| in_byte | input | 8 | Descriptor byte |
| wide_mode | input | 1 | 1 = 32-bit addressing, 0 = 16-bit addressing |
| ext_r | input | 1 | Extension bit for the reg field |
| ext_x | input | 1 | Extension bit for the index field |
| ext_b | input | 1 | Extension bit for the base or rm field |
| f_mod | output | 2 | mod field |
| f_reg | output | 4 | reg field with extension bit |
| f_rm | output | 4 | rm field with extension bit |
| is_reg | output | 1 | Operand is a register |
| reg_idx | output | 4 | Register number when `is_reg`=1 |
| has_sib | output | 1 | A scale-index-base byte was taken |
| sib_scale | output | 2 | Scale field |
| sib_index | output | 4 | Index field with extension bit |
| sib_base | output | 4 | Base field with extension bit |
| disp_len | output | 3 | Displacement byte count (0, 1, 2 or 4) |
| disp_val | output | 32 | Displacement value, sign-extended when 1 byte long |
| done | output | 1 | One-cycle completion pulse |

## Verification
The descriptors sent cover every mod value in both addressing widths. This separates the 16-bit rm=6 rule from the 32-bit rm=5 rule, and it shows which rm value triggers a scale-index-base byte. Scale-index-base bytes are sent with base 5, base 13 (base 5 with the extension bit set) and an ordinary base, which tells the base-driven length apart from the mod-driven one. Negative one-byte displacements in both widths expose the sign-extension width. The extension inputs are set in narrow mode to show that they are ignored there, and set in wide mode to show which field each one reaches. Idle gaps between bytes, and a byte offered during the completion cycle, show that only handshaken bytes are consumed and that the outputs hold after completion.

// File: rtl/addr_form_pkg.sv
package addr_form_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SIB  = 2'd1,
        S_DISP = 2'd2,
        S_DONE = 2'd3
    } dec_state_e;

    localparam logic [1:0] MOD_MEM0 = 2'b00;
    localparam logic [1:0] MOD_MEM1 = 2'b01;
    localparam logic [1:0] MOD_MEM2 = 2'b10;
    localparam logic [1:0] MOD_REG  = 2'b11;
endpackage

// File: rtl/addr_form_lenrule.sv
module addr_form_lenrule
    import addr_form_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             wide,
    input  logic [1:0]       mod_f,
    input  logic [2:0]       rm_f,
    output logic [LEN_W-1:0] len,
    output logic             need_sib,
    output logic             reg_form
);
    always_comb begin
        reg_form = (mod_f == MOD_REG);
        need_sib = wide && !reg_form && (rm_f == 3'd4);
        unique case (mod_f)
            MOD_MEM0: begin
                if (wide) len = (rm_f == 3'd5) ? LEN_W'(4) : LEN_W'(0);
                else      len = (rm_f == 3'd6) ? LEN_W'(2) : LEN_W'(0);
            end
            MOD_MEM1: len = LEN_W'(1);
            MOD_MEM2: len = wide ? LEN_W'(4) : LEN_W'(2);
            default:  len = LEN_W'(0);
        endcase
    end
endmodule

// File: rtl/addr_form_disp.sv
module addr_form_disp #(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 32,
    parameter int POS_W  = $clog2(DISP_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [POS_W-1:0]  pos,
    input  logic              single,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    output logic [DISP_W-1:0] val
);
    localparam int HALF_W = DISP_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (clear) begin
            val <= '0;
        end else if (load) begin
            if (single) begin
                if (wide) val <= {{(DISP_W-BYTE_W){din[BYTE_W-1]}}, din};
                else      val <= {{HALF_W{1'b0}}, {(HALF_W-BYTE_W){din[BYTE_W-1]}}, din};
            end else begin
                val[pos*BYTE_W +: BYTE_W] <= din;
            end
        end
    end
endmodule

// File: rtl/addr_form_decoder.sv
module addr_form_decoder
    import addr_form_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 32,
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              wide_mode,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    output logic [1:0]        f_mod,
    output logic [IDX_W-1:0]  f_reg,
    output logic [IDX_W-1:0]  f_rm,
    output logic              is_reg,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              has_sib,
    output logic [1:0]        sib_scale,
    output logic [IDX_W-1:0]  sib_index,
    output logic [IDX_W-1:0]  sib_base,
    output logic [LEN_W-1:0]  disp_len,
    output logic [DISP_W-1:0] disp_val,
    output logic              done
);
    localparam int POS_W = $clog2(DISP_W / BYTE_W);

    dec_state_e       state_q, state_d;
    logic [POS_W-1:0] cnt_q;
    logic             wide_q, ext_x_q, ext_b_q;
    logic             accept;

    logic [LEN_W-1:0] first_len;
    logic             first_sib, first_reg;
    logic [IDX_W-1:0] new_base;
    logic [LEN_W-1:0] sib_len;
    logic [IDX_W-1:0] rm_ext;

    assign in_ready = (state_q != S_DONE);
    assign done     = (state_q == S_DONE);
    assign accept   = in_valid && in_ready;

    addr_form_lenrule #(.LEN_W(LEN_W)) u_len (
        .wide     (wide_mode),
        .mod_f    (in_byte[7:6]),
        .rm_f     (in_byte[2:0]),
        .len      (first_len),
        .need_sib (first_sib),
        .reg_form (first_reg)
    );

    addr_form_disp #(.BYTE_W(BYTE_W), .DISP_W(DISP_W), .POS_W(POS_W)) u_disp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept && state_q == S_IDLE),
        .load   (accept && state_q == S_DISP),
        .pos    (cnt_q),
        .single (disp_len == LEN_W'(1)),
        .wide   (wide_q),
        .din    (in_byte),
        .val    (disp_val)
    );

    always_comb begin
        rm_ext   = {wide_mode & ext_b, in_byte[2:0]};
        new_base = {wide_q & ext_b_q, in_byte[2:0]};
        sib_len  = (f_mod == MOD_MEM0 && new_base == IDX_W'(5)) ? LEN_W'(4) : disp_len;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) begin
                if (first_reg)                    state_d = S_DONE;
                else if (first_sib)               state_d = S_SIB;
                else if (first_len != LEN_W'(0))  state_d = S_DISP;
                else                              state_d = S_DONE;
            end
            S_SIB: if (accept) begin
                state_d = (sib_len != LEN_W'(0)) ? S_DISP : S_DONE;
            end
            S_DISP: if (accept && (LEN_W'(cnt_q) + LEN_W'(1) == disp_len)) begin
                state_d = S_DONE;
            end
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Field and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_mod <= '0; f_reg <= '0; f_rm <= '0;
            is_reg <= 1'b0; reg_idx <= '0; has_sib <= 1'b0;
            sib_scale <= '0; sib_index <= '0; sib_base <= '0;
            disp_len <= '0; cnt_q <= '0;
            wide_q <= 1'b0; ext_x_q <= 1'b0; ext_b_q <= 1'b0;
        end else if (accept) begin
            unique case (state_q)
                S_IDLE: begin
                    f_mod     <= in_byte[7:6];
                    f_reg     <= {wide_mode & ext_r, in_byte[5:3]};
                    f_rm      <= first_sib ? {1'b0, in_byte[2:0]} : rm_ext;
                    is_reg    <= first_reg;
                    reg_idx   <= first_reg ? rm_ext : '0;
                    has_sib   <= first_sib;
                    sib_scale <= '0;
                    sib_index <= '0;
                    sib_base  <= '0;
                    disp_len  <= first_len;
                    cnt_q     <= '0;
                    wide_q    <= wide_mode;
                    ext_x_q   <= ext_x;
                    ext_b_q   <= ext_b;
                end
                S_SIB: begin
                    sib_scale <= in_byte[7:6];
                    sib_index <= {wide_q & ext_x_q, in_byte[5:3]};
                    sib_base  <= new_base;
                    disp_len  <= sib_len;
                end
                S_DISP:  cnt_q <= cnt_q + POS_W'(1);
                default: ;
            endcase
        end
    end

    // Assertions
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(f_mod) && $stable(f_reg) && $stable(f_rm) &&
                  $stable(is_reg) && $stable(disp_val) && $stable(disp_len)));
    p_reg_form_bare_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> (disp_len == '0 && !has_sib));
    p_sib_wide_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        has_sib |-> wide_q);
    p_narrow_no_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (!f_reg[IDX_W-1] && !f_rm[IDX_W-1] && !reg_idx[IDX_W-1]));
    p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_len == 3'd0 || disp_len == 3'd1 || disp_len == 3'd2 || disp_len == 3'd4));
    p_short_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wide_q && disp_len == 3'd1) |-> (disp_val[DISP_W-1:BYTE_W] == {(DISP_W-BYTE_W){disp_val[BYTE_W-1]}}));
endmodule

// File: tb/sim_addr_form_decoder.sv
module sim_addr_form_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        wide_mode = 1'b0;
    logic        ext_r = 1'b0, ext_x = 1'b0, ext_b = 1'b0;
    logic [1:0]  f_mod;
    logic [3:0]  f_reg, f_rm, reg_idx, sib_index, sib_base;
    logic        is_reg, has_sib, done;
    logic [1:0]  sib_scale;
    logic [2:0]  disp_len;
    logic [31:0] disp_val;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    addr_form_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .wide_mode(wide_mode), .ext_r(ext_r), .ext_x(ext_x),
        .ext_b(ext_b), .f_mod(f_mod), .f_reg(f_reg), .f_rm(f_rm), .is_reg(is_reg),
        .reg_idx(reg_idx), .has_sib(has_sib), .sib_scale(sib_scale),
        .sib_index(sib_index), .sib_base(sib_base), .disp_len(disp_len),
        .disp_val(disp_val), .done(done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected values computed by the behavioural model
    logic [1:0]  e_mod, e_scale;
    logic [3:0]  e_reg, e_rm, e_idx, e_sindex, e_sbase;
    logic        e_isreg, e_sib;
    logic [2:0]  e_len;
    logic [31:0] e_disp;

    task automatic check_fields(string xtag, string ltag);
        chk("R1", "mod", 32'(f_mod), 32'(e_mod));
        chk(xtag, "reg", 32'(f_reg), 32'(e_reg));
        chk(xtag, "rm", 32'(f_rm), 32'(e_rm));
        chk("R8", "is_reg", 32'(is_reg), 32'(e_isreg));
        chk("R8", "reg_idx", 32'(reg_idx), 32'(e_idx));
        chk("R4", "has_sib", 32'(has_sib), 32'(e_sib));
        chk("R4", "scale", 32'(sib_scale), 32'(e_scale));
        chk(xtag, "index", 32'(sib_index), 32'(e_sindex));
        chk(xtag, "base", 32'(sib_base), 32'(e_sbase));
        chk(ltag, "disp_len", 32'(disp_len), 32'(e_len));
        chk("R6", "disp_val", disp_val, e_disp);
    endtask

    task automatic run_case(string xtag, string ltag, bit wide, bit er, bit ex, bit eb,
                            logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                            logic [7:0] b3, logic [7:0] b4, logic [7:0] b5, bit gap);
        logic [7:0] bs [6];
        int n;
        int total;
        logic [2:0] rm3;
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4; bs[5] = b5;
        // Behavioural reference
        e_mod = b0[7:6];
        e_reg = wide ? {er, b0[5:3]} : {1'b0, b0[5:3]};
        rm3 = b0[2:0];
        e_isreg = 0; e_idx = 0; e_sib = 0; e_scale = 0; e_sindex = 0; e_sbase = 0;
        n = 1;
        e_len = 0;
        if (e_mod == 2'd3) begin
            e_isreg = 1;
            e_rm = wide ? {eb, rm3} : {1'b0, rm3};
            e_idx = e_rm;
        end else if (wide) begin
            if (rm3 == 3'd4) begin
                e_sib = 1; n = 2; e_rm = 4'd4;
                e_scale = b1[7:6];
                e_sindex = {ex, b1[5:3]};
                e_sbase = {eb, b1[2:0]};
                if (e_mod == 2'd1)      e_len = 1;
                else if (e_mod == 2'd2) e_len = 4;
                else                    e_len = (e_sbase == 4'd5) ? 3'd4 : 3'd0;
            end else begin
                e_rm = {eb, rm3};
                if (e_mod == 2'd1)      e_len = 1;
                else if (e_mod == 2'd2) e_len = 4;
                else                    e_len = (rm3 == 3'd5) ? 3'd4 : 3'd0;
            end
        end else begin
            e_rm = {1'b0, rm3};
            if (e_mod == 2'd1)      e_len = 1;
            else if (e_mod == 2'd2) e_len = 2;
            else                    e_len = (rm3 == 3'd6) ? 3'd2 : 3'd0;
        end
        e_disp = 0;
        for (int k = 0; k < int'(e_len); k++) e_disp = e_disp | (32'(bs[n+k]) << (8*k));
        if (e_len == 1) begin
            if (wide) e_disp = {{24{bs[n][7]}}, bs[n]};
            else      e_disp = {16'h0, {8{bs[n][7]}}, bs[n]};
        end
        total = n + int'(e_len);

        // Drive one byte per handshake, compare on every clock
        for (int i = 0; i < total; i++) begin
            if (i > 0 && gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte = 8'hA5;
                chk("R9", "done mid-gap", 32'(done), 0);
            end
            @(negedge clk);
            if (i > 0) chk("R9", "done mid-descriptor", 32'(done), 0);
            chk("R9", "ready while decoding", 32'(in_ready), 1);
            in_valid = 1'b1;
            in_byte = bs[i];
            wide_mode = wide; ext_r = er; ext_x = ex; ext_b = eb;
        end
        @(negedge clk);
        chk("R9", "done after last byte", 32'(done), 1);
        chk("R9", "ready low in done cycle", 32'(in_ready), 0);
        check_fields(xtag, ltag);
        // Offer a byte during the done cycle: it must be ignored
        in_valid = 1'b1;
        in_byte = 8'hFF;
        wide_mode = ~wide;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "done single cycle", 32'(done), 0);
        chk("R9", "ready back", 32'(in_ready), 1);
        check_fields(xtag, ltag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "done", 32'(done), 0);
        chk("R10", "is_reg", 32'(is_reg), 0);
        chk("R10", "mod", 32'(f_mod), 0);
        chk("R10", "disp_val", disp_val, 0);
        chk("R10", "disp_len", 32'(disp_len), 0);
        chk("R10", "has_sib", 32'(has_sib), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready", 32'(in_ready), 1);

        // 16-bit addressing (R2)
        run_case("R1", "R2", 0, 0, 0, 0, 8'h10, 0, 0, 0, 0, 0, 0);
        run_case("R1", "R2", 0, 0, 0, 0, 8'h06, 8'h34, 8'h12, 0, 0, 0, 0);
        run_case("R1", "R2", 0, 0, 0, 0, 8'h4B, 8'h80, 0, 0, 0, 0, 0);
        run_case("R1", "R2", 0, 0, 0, 0, 8'hBF, 8'hCD, 8'hAB, 0, 0, 0, 1);
        run_case("R1", "R2", 0, 0, 0, 0, 8'h04, 0, 0, 0, 0, 0, 0);
        // R7: extension inputs ignored in narrow mode, register form (R8)
        run_case("R7", "R8", 0, 1, 1, 1, 8'hFD, 0, 0, 0, 0, 0, 0);
        // 32-bit addressing (R3)
        run_case("R7", "R8", 1, 1, 0, 1, 8'hC1, 0, 0, 0, 0, 0, 0);
        run_case("R1", "R3", 1, 0, 0, 0, 8'h05, 8'h78, 8'h56, 8'h34, 8'h12, 0, 0);
        run_case("R1", "R3", 1, 0, 0, 0, 8'h52, 8'hF0, 0, 0, 0, 0, 0);
        run_case("R1", "R3", 1, 0, 0, 0, 8'h80, 8'h01, 8'h02, 8'h03, 8'h84, 0, 1);
        run_case("R7", "R3", 1, 0, 0, 1, 8'h01, 0, 0, 0, 0, 0, 0);
        // Scale-index-base forms (R4, R5)
        run_case("R4", "R5", 1, 0, 0, 0, 8'h04, 8'h9D, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 0);
        run_case("R7", "R5", 1, 0, 1, 0, 8'h44, 8'h5D, 8'h85, 0, 0, 0, 1);
        run_case("R7", "R5", 1, 1, 1, 1, 8'h3C, 8'h48, 0, 0, 0, 0, 0);
        run_case("R7", "R5", 1, 0, 0, 1, 8'h04, 8'hC5, 0, 0, 0, 0, 0);
        run_case("R4", "R5", 1, 0, 0, 0, 8'h84, 8'h20, 8'h11, 8'h22, 8'h33, 8'h44, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule